// File: doc/BRIEF.md
# Chip Control and Interrupt Aggregator

This block is the top-level control point of a chip built from several functional modules. A host processor reaches it over a plain 16-bit register bus. Through it the host sets a control word that holds the per-module interrupt enables, the transmit clock source select, the clock mode and an active-low software reset. The host can also read a status word that shows which modules need service.

Each module supplies an event vector and an enable vector of its own. A module's service flag is set when any of its events is both raised and enabled. The host-side enable for that module in the control word then gates the flag a second time, and all gated flags are ORed onto a single level-sensitive interrupt line.

The software reset bit drives a module reset output. That output is stretched so the other modules see a reset pulse long enough for the synchronous reset to take hold.

Top module: `chip_ctrl_hub`

## Requirements
- R1: After `rst_n` is sampled low, the control word at address 0x0000 reads 0x0000, and all outputs derived from it are 0.
- R2: A write to address 0x0000 stores all 16 bits, including the reserved field 10:5 and the page bit 11. A later read at 0x0000 returns the same value.
- R3: Status bit m (m = 0..4, in the order time-division port, transmit segmentation, receive reassembly, cell multiplexer, timing recovery) is 1 exactly when `evt_flags[m*16 +: 16] & evt_enables[m*16 +: 16]` is nonzero. The status word is read at address 0x0002.
- R4: Status bits 15:5 read as 0. A write to 0x0002 changes neither the control word nor the status word.
- R5: `irq` is high exactly when some module m has both its status bit and control bit m at 1. It follows event, enable and control changes with no register delay.
- R6: While control bit 15 is 0 or `rst_n` is low, `mod_rst_n` is 0. After a write that sets bit 15, `mod_rst_n` stays 0 through the next 75 clock edges and goes to 1 at the 76th edge.
- R7: Clearing control bit 15 by a write drives `mod_rst_n` to 0 at the clock edge that follows the write.
- R8: `txclk_sel` mirrors control bits 13:12 (00 external oscillator / pin released, 01 master/2, 10 master/4, 11 secondary clock). `ext_clk_on` mirrors control bit 14 (0 = every secondary clock replaced by master/4).
- R9: A read of any address other than 0x0000 and 0x0002 returns 0. A write to such an address changes no state.
- R10: `bus_rdata` carries the read value in the cycle after a `bus_rd` edge and is 0 in any cycle that follows an edge without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| evt_flags | input | 80 | Event bits, 16 per module, module m at bits m*16+15:m*16 |
| evt_enables | input | 80 | Per-event enable bits, same layout as `evt_flags` |
| irq | output | 1 | Active-high level interrupt |
| mod_rst_n | output | 1 | Active-low reset to all non-host modules |
| txclk_sel | output | 2 | Transmit clock source select |
| ext_clk_on | output | 1 | 1 = secondary clocks pass through, 0 = substituted |

## Verification
The hardest situation to reach is the exact release edge of the stretched module reset. The edge only comes 76 cycles after a control write, and it has to be told apart from releases one cycle early or late. The bench sets bit 15 with a single write and then checks `mod_rst_n` after every following edge until release. It then clears the bit and checks the edge where the reset drops again.

The two-level gating is driven from a vector table in which events and enables overlap or miss within one module, and the control enables mask flags that are present.

// File: rtl/chip_ctrl_pkg.sv
// Shared constants for the chip control hub: bus width, register
// addresses, control-word field positions and default sizes.
package chip_ctrl_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 16;
    localparam int NUM_MOD  = 5;
    localparam int EVT_W    = 16;
    localparam int HOLD_CYC = 75;

    localparam logic [ADDR_W-1:0] CTL_ADDR = 16'h0000;
    localparam logic [ADDR_W-1:0] STS_ADDR = 16'h0002;

    localparam int SRES_BIT  = 15;
    localparam int CMODE_BIT = 14;
    localparam int TXSEL_HI  = 13;
    localparam int TXSEL_LO  = 12;
endpackage

// File: rtl/svc_flag_gen.sv
// svc_flag_gen: forms one service flag per module as the OR of that
// module's event bits masked by its own enable bits.
// Assumes module m occupies slice [m*EVT_W +: EVT_W] of both vectors.
module svc_flag_gen #(
    parameter int NUM_MOD = 5,
    parameter int EVT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_MOD*EVT_W-1:0] evt_flags,
    input  logic [NUM_MOD*EVT_W-1:0] evt_enables,
    output logic [NUM_MOD-1:0]       svc
);
    // One reduction per module slice.
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        assign svc[m] = |(evt_flags[m*EVT_W +: EVT_W] & evt_enables[m*EVT_W +: EVT_W]);
    end

    // R3
    svc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flags == '0) |-> (svc == '0));
endmodule

// File: rtl/ctl_word_regs.sv
// ctl_word_regs: holds the control word, decodes the register bus and
// returns registered read data for the control and status words.
// Assumes single-cycle strobes; unmapped reads return 0.
module ctl_word_regs
    import chip_ctrl_pkg::*;
#(
    parameter int NUM_MOD = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_MOD-1:0] svc,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_MOD-1:0] mod_ie,
    output logic               sres,
    output logic               cmode,
    output logic [1:0]         txsel
);
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] sts_word;
    logic [DATA_W-1:0] rd_mux;
    logic              hit_ctl;
    logic              hit_sts;

    assign hit_ctl = (bus_addr == CTL_ADDR);
    assign hit_sts = (bus_addr == STS_ADDR);

    // Control word storage; only the control address is writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (bus_wr && hit_ctl)
            ctl_q <= bus_wdata;
    end

    // Status word: service flags in the low bits, zeros above.
    always_comb begin
        sts_word = '0;
        sts_word[NUM_MOD-1:0] = svc;
    end

    // Read source selection by address.
    always_comb begin
        if (hit_ctl)
            rd_mux = ctl_q;
        else if (hit_sts)
            rd_mux = sts_word;
        else
            rd_mux = '0;
    end

    // Registered read data, cleared on cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
        else
            bus_rdata <= '0;
    end

    assign mod_ie = ctl_q[NUM_MOD-1:0];
    assign sres   = ctl_q[SRES_BIT];
    assign cmode  = ctl_q[CMODE_BIT];
    assign txsel  = ctl_q[TXSEL_HI:TXSEL_LO];

    // R1
    ctl_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0));
    // R4
    sts_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_sts) |=> $stable(ctl_q));
    // R9
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_ctl && !hit_sts) |=> (bus_rdata == '0));
    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: rtl/rst_stretch.sv
// rst_stretch: turns the software reset bit into a module reset that is
// held low for HOLD_CYC cycles after the bit rises and releases one edge
// later. Assumes the bit is synchronous to clk.
module rst_stretch #(
    parameter int HOLD_CYC = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sres,
    output logic mod_rst_n
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] hold_cnt;

    // Count cycles with the reset bit released, then release the output.
    always_ff @(posedge clk) begin
        if (!rst_n || !sres) begin
            hold_cnt  <= '0;
            mod_rst_n <= 1'b0;
        end else if (hold_cnt != HOLD_V) begin
            hold_cnt  <= hold_cnt + 1'b1;
            mod_rst_n <= 1'b0;
        end else begin
            mod_rst_n <= 1'b1;
        end
    end

    // Checker: independent run length of the reset bit, saturating.
    logic [CNT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n || !sres)
            run_len <= '0;
        else if (run_len <= (CNT_W+1)'(HOLD_CYC))
            run_len <= run_len + 1'b1;
    end

    // R6
    rst_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_rst_n) |-> (run_len > (CNT_W+1)'(HOLD_CYC)));
    // R7
    rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sres |=> !mod_rst_n);
endmodule

// File: rtl/chip_ctrl_hub.sv
// chip_ctrl_hub: top of the control and interrupt aggregator. Combines
// per-module service flags with the control-word enables into one level
// interrupt, stretches the software reset, and exports clock selects.
// Assumes all inputs are synchronous to clk.
module chip_ctrl_hub
    import chip_ctrl_pkg::*;
#(
    parameter int NUM_MOD  = chip_ctrl_pkg::NUM_MOD,
    parameter int EVT_W    = chip_ctrl_pkg::EVT_W,
    parameter int HOLD_CYC = chip_ctrl_pkg::HOLD_CYC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic [NUM_MOD*EVT_W-1:0] evt_flags,
    input  logic [NUM_MOD*EVT_W-1:0] evt_enables,
    output logic                     irq,
    output logic                     mod_rst_n,
    output logic [1:0]               txclk_sel,
    output logic                     ext_clk_on
);
    logic [NUM_MOD-1:0] svc;
    logic [NUM_MOD-1:0] mod_ie;
    logic               sres;

    svc_flag_gen #(.NUM_MOD(NUM_MOD), .EVT_W(EVT_W)) u_svc (
        .clk(clk), .rst_n(rst_n),
        .evt_flags(evt_flags), .evt_enables(evt_enables), .svc(svc)
    );

    ctl_word_regs #(.NUM_MOD(NUM_MOD)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .svc(svc), .bus_rdata(bus_rdata),
        .mod_ie(mod_ie), .sres(sres), .cmode(ext_clk_on), .txsel(txclk_sel)
    );

    rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_rst (
        .clk(clk), .rst_n(rst_n), .sres(sres), .mod_rst_n(mod_rst_n)
    );

    // Second-level gating and merge onto the interrupt line.
    assign irq = |(svc & mod_ie);

    // R5
    irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc == '0) |-> !irq);
    // R5
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mod_ie != '0));
endmodule

// File: tb/chip_ctrl_hub_bench.sv
module chip_ctrl_hub_bench;
    localparam int CLK_P = 10;
    localparam int HOLD  = 75;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [79:0] evt_flags = '0;
    logic [79:0] evt_enables = '0;
    logic        irq, mod_rst_n, ext_clk_on;
    logic [1:0]  txclk_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    chip_ctrl_hub u_chip_ctrl_hub (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_flags(evt_flags), .evt_enables(evt_enables), .irq(irq),
        .mod_rst_n(mod_rst_n), .txclk_sel(txclk_sel), .ext_clk_on(ext_clk_on)
    );

    // {evt, en, ctl enables, expected status[4:0], expected irq}
    localparam logic [170:0] VEC [0:6] = '{
        {80'h0, {5{16'hFFFF}}, 5'b11111, 5'b00000, 1'b0},
        {80'h0000_0000_0000_0000_0001, 80'h0000_0000_0000_0000_0001, 5'b00001, 5'b00001, 1'b1},
        {80'h0000_0000_0000_8000_0000, 80'h0000_0000_0000_0001_0000, 5'b11111, 5'b00000, 1'b0},
        {80'h0000_0000_00F0_0000_0000, 80'h0000_0000_0010_0000_0000, 5'b00011, 5'b00100, 1'b0},
        {80'h8000_1234_0000_0000_0000, 80'h8000_0004_0000_0000_0000, 5'b10000, 5'b11000, 1'b1},
        {{5{16'hFFFF}}, {5{16'hFFFF}}, 5'b00000, 5'b11111, 1'b0},
        {{5{16'hFFFF}}, {5{16'hFFFF}}, 5'b01000, 5'b11111, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        bit ok;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        bus_read(16'h0000, rd);
        check(rd == 16'h0000, "R1 ctl reset", rd, 0);
        check({mod_rst_n, txclk_sel, ext_clk_on, irq} == 5'b0, "R1 outputs", {mod_rst_n, txclk_sel, ext_clk_on, irq}, 0);
        // R10 idle rdata
        @(negedge clk);
        check(bus_rdata == 16'h0, "R10 idle rdata", bus_rdata, 0);

        // R3 R5 vector table walk
        for (int i = 0; i < 7; i++) begin
            logic [15:0] ctl_v;
            @(negedge clk);
            evt_flags   = VEC[i][170:91];
            evt_enables = VEC[i][90:11];
            ctl_v = 16'hCC00 | {11'b0, VEC[i][10:6]};
            bus_write(16'h0000, ctl_v);
            #1;
            check(irq == VEC[i][0], "R5 irq vector", irq, VEC[i][0]);
            bus_read(16'h0002, rd);
            check(rd == {11'b0, VEC[i][5:1]}, "R3 status vector", rd, {11'b0, VEC[i][5:1]});
        end

        // R5 combinational drop: clear enable of module 3 with ctl enable set
        @(negedge clk);
        evt_enables[63:48] = 16'h0;
        #1;
        check(irq == 1'b0, "R5 irq drop on enable clear", irq, 0);
        evt_enables[63:48] = 16'h0001;
        #1;
        check(irq == 1'b1, "R5 irq rise", irq, 1);

        // R2 full readback including reserved and page bits
        bus_write(16'h0000, 16'h4C1F);
        bus_read(16'h0000, rd);
        check(rd == 16'h4C1F, "R2 readback", rd, 16'h4C1F);
        bus_write(16'h0000, 16'h0BE0);
        bus_read(16'h0000, rd);
        check(rd == 16'h0BE0, "R2 readback reserved", rd, 16'h0BE0);

        // R4 write to status ignored, upper bits zero
        bus_write(16'h0002, 16'hFFFF);
        bus_read(16'h0000, rd);
        check(rd == 16'h0BE0, "R4 ctl unchanged by status write", rd, 16'h0BE0);
        bus_read(16'h0002, rd);
        check(rd == 16'h001F, "R4 status after write", rd, 16'h001F);

        // R9 unmapped reads and writes
        bus_write(16'h0010, 16'hFFFF);
        bus_read(16'h0000, rd);
        check(rd == 16'h0BE0, "R9 unmapped write no effect", rd, 16'h0BE0);
        bus_read(16'h0004, rd);
        check(rd == 16'h0, "R9 unmapped read 0x4", rd, 0);
        bus_read(16'h0001, rd);
        check(rd == 16'h0, "R9 unmapped read 0x1", rd, 0);
        bus_read(16'hFFFE, rd);
        check(rd == 16'h0, "R9 unmapped read 0xFFFE", rd, 0);

        // R8 clock selectors
        for (int s = 0; s < 4; s++) begin
            bus_write(16'h0000, 16'h0C00 | 16'(s << 12));
            check(txclk_sel == 2'(s) && ext_clk_on == 1'b0, "R8 txclk_sel", {txclk_sel, ext_clk_on}, {2'(s), 1'b0});
        end
        bus_write(16'h0000, 16'h4C00);
        check(ext_clk_on == 1'b1, "R8 ext_clk_on", ext_clk_on, 1);

        // R6 stretched release
        check(mod_rst_n == 1'b0, "R6 held while bit clear", mod_rst_n, 0);
        bus_write(16'h0000, 16'hCC00);
        ok = 1;
        for (int k = 1; k <= HOLD; k++) begin
            @(negedge clk);
            if (mod_rst_n !== 1'b0) ok = 0;
        end
        check(ok, "R6 low through 75 edges", mod_rst_n, 0);
        @(negedge clk);
        check(mod_rst_n == 1'b1, "R6 release at edge 76", mod_rst_n, 1);

        // R7 drop after clearing
        bus_write(16'h0000, 16'h4C00);
        check(mod_rst_n == 1'b1, "R7 still high at write edge", mod_rst_n, 1);
        @(negedge clk);
        check(mod_rst_n == 1'b0, "R7 low at next edge", mod_rst_n, 0);

        // R1 R6 reset mid-operation
        bus_write(16'h0000, 16'hCC1F);
        repeat (HOLD + 3) @(negedge clk);
        check(mod_rst_n == 1'b1, "R6 released before reset", mod_rst_n, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(mod_rst_n == 1'b0 && irq == 1'b0, "R6 reset forces module reset", {mod_rst_n, irq}, 0);
        rst_n = 1'b1;
        bus_read(16'h0000, rd);
        check(rd == 16'h0, "R1 ctl cleared by reset", rd, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule